// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a single-port synchronous static memory meant to hold the data array of a cache. Every input except the output enable is captured on the rising clock edge. The inputs are address, write data, select, both burst strobes, the advance input and the two lane write enables. The array access happens on the following edge. Read data passes through an output register, so a word appears one cycle after the edge that sampled its address.

A burst opens when either the processor-side strobe or the controller-side strobe is seen at an edge. That edge loads the external address as the burst base. Later accesses in the burst come from an internal two-bit offset counter. The counter moves only on edges where the advance input is high, and its value is XORed into the two lowest base address bits, which gives an interleaved order. Two write enables cover the lower and upper halves of the word. The output enable gates the data output with no clock involved.

A small state machine tracks whether the device is selected. It has two states:
- `ST_DESEL`: no access takes place. This is the reset state.
- `ST_BURST`: the device follows the current burst.

The machine moves from `ST_DESEL` to `ST_BURST` when either strobe is seen with select high. A processor strobe is ignored while select is low. It moves from `ST_BURST` back to `ST_DESEL` when the controller strobe is seen with select low and no processor strobe with select high is present. A processor strobe with select high has priority over the controller strobe.

Top module: `bsram_top`

## Requirements
- R1: After reset the device is deselected and `dout_en` is low. Idle cycles with no strobe cause no access.
- R2: A read whose inputs are sampled at edge N drives its word with `dout_en` high from edge N+1 onward, provided `oe` is high.
- R3: While `oe` is low, `dout_en` is low and `dout` is zero. The change follows `oe` at once, with no clock edge needed.
- R4: `cpu_stb` with `sel` high starts a burst at `addr` and is always a read. The write enables sampled on that edge leave the array unchanged.
- R5: `ctl_stb` with `sel` high starts a burst at `addr`. `we_lo` writes data bits 0..8 and `we_hi` writes bits 9..17, each on its own. With neither enable set, the access is a read. A write cycle leaves `dout_en` low.
- R6: Each edge with `adv` high inside a burst moves to the next address. Its two low bits are the base low bits XOR n, for n = 1, 2, 3, and the fourth advance wraps back to n = 0. The upper address bits never change within a burst.
- R7: Inside a burst, an edge with no effective strobe and `adv` low repeats the access at the current address.
- R8: `cpu_stb` with `sel` low has no effect, and the burst continues as if no strobe were present.
- R9: `ctl_stb` with `sel` low deselects the device. No read or write takes place until a strobe arrives with `sel` high.
- R10: Advance cycles in a burst write the lanes whose enables are sampled high, at the advanced address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address, loaded at a strobe |
| din | input | DATA_W | Write data |
| sel | input | 1 | Device select |
| cpu_stb | input | 1 | Processor-side burst start strobe |
| ctl_stb | input | 1 | Controller-side burst start strobe |
| adv | input | 1 | Burst advance |
| we_lo | input | 1 | Write enable for the lower lane |
| we_hi | input | 1 | Write enable for the upper lane |
| oe | input | 1 | Asynchronous output enable |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | High while `dout` carries valid read data |

## Verification
The bench builds the block with a 6-bit address, which gives 64 words, and the default 18-bit width split into two 9-bit lanes. With this depth every word can be filled through write bursts that start at each of the four low-bit offsets. Read bursts then cross block boundaries and reach the wrap back to the base. Lane writes using all-ones and all-zeros patterns show exactly which 9 bits each enable touches.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    localparam int BURST_W = 2;
    localparam int LANES   = 2;

    typedef enum logic {
        ST_DESEL = 1'b0,
        ST_BURST = 1'b1
    } bst_state_e;
endpackage

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt
);
    always_comb begin
        cnt_nxt = step ? CNT_W'(cnt_q + 1'b1) : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= '0;
        else if (step) cnt_q <= cnt_nxt;
    end

    // R6: each advance moves the offset by one, wrapping modulo 4
    assert_offset_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        $past(step && !load) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              sel,
    input  logic              cpu_stb,
    input  logic              ctl_stb,
    input  logic              adv,
    input  logic              we_lo,
    input  logic              we_hi,
    output logic              acc_valid,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [LANES-1:0]  acc_we,
    output logic [DATA_W-1:0] acc_din
);
    // sampled inputs
    logic [ADDR_W-1:0] addr_r;
    logic [DATA_W-1:0] din_r;
    logic              sel_r, cpu_r, ctl_r, adv_r, wlo_r, whi_r;

    bst_state_e        state_q, state_d;
    logic [ADDR_W-1:0] base_q;
    logic              cpu_go, ctl_go, ctl_off, cont;
    logic [BURST_W-1:0] off_q, off_nxt;
    logic              primed;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_r <= '0;
            din_r  <= '0;
            sel_r  <= 1'b0;
            cpu_r  <= 1'b0;
            ctl_r  <= 1'b0;
            adv_r  <= 1'b0;
            wlo_r  <= 1'b0;
            whi_r  <= 1'b0;
            primed <= 1'b0;
        end else begin
            addr_r <= addr;
            din_r  <= din;
            sel_r  <= sel;
            cpu_r  <= cpu_stb;
            ctl_r  <= ctl_stb;
            adv_r  <= adv;
            wlo_r  <= we_lo;
            whi_r  <= we_hi;
            primed <= 1'b1;
        end
    end

    // decode of the sampled edge
    always_comb begin
        cpu_go  = cpu_r & sel_r;
        ctl_go  = ~cpu_go & ctl_r & sel_r;
        ctl_off = ~cpu_go & ctl_r & ~sel_r;
        cont    = ~cpu_go & ~ctl_r & (state_q == ST_BURST);
    end

    bsram_burst_ctr #(.CNT_W(BURST_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .load    (cpu_go | ctl_go),
        .step    (cont & adv_r),
        .cnt_q   (off_q),
        .cnt_nxt (off_nxt)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DESEL;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            if (cpu_go | ctl_go) base_q <= addr_r;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DESEL: if (cpu_go | ctl_go) state_d = ST_BURST;
            ST_BURST: if (ctl_off)         state_d = ST_DESEL;
        endcase
    end

    // access command
    always_comb begin
        acc_valid = 1'b0;
        acc_addr  = {base_q[ADDR_W-1:BURST_W], base_q[BURST_W-1:0] ^ off_nxt};
        acc_we    = '0;
        acc_din   = din_r;
        unique case (state_q)
            ST_DESEL: begin
                if (cpu_go | ctl_go) begin
                    acc_valid = 1'b1;
                    acc_addr  = addr_r;
                    acc_we    = ctl_go ? {whi_r, wlo_r} : '0;
                end
            end
            ST_BURST: begin
                if (cpu_go | ctl_go) begin
                    acc_valid = 1'b1;
                    acc_addr  = addr_r;
                    acc_we    = ctl_go ? {whi_r, wlo_r} : '0;
                end else if (cont) begin
                    acc_valid = 1'b1;
                    acc_we    = {whi_r, wlo_r};
                end
            end
        endcase
    end

    // R4: a processor strobe with select never writes
    assert_cpu_read_R4: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(cpu_stb && sel)) |-> (acc_we == '0));

    // R9: a deselecting controller strobe produces no access
    assert_desel_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(ctl_stb && !sel && !(cpu_stb && sel))) |-> !acc_valid);

    // R6: upper address bits stay at the base during continuation
    assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && cont) |-> (acc_addr[ADDR_W-1:BURST_W] == base_q[ADDR_W-1:BURST_W]));
endmodule

// File: rtl/bsram_array.sv
module bsram_array
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [LANES-1:0]  acc_we,
    input  logic [DATA_W-1:0] acc_din,
    output logic [DATA_W-1:0] rd_q,
    output logic              rd_vld_q
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (acc_valid) begin
            for (int g = 0; g < LANES; g++) begin
                if (acc_we[g]) mem[acc_addr][g*LANE_W +: LANE_W] <= acc_din[g*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q     <= '0;
            rd_vld_q <= 1'b0;
        end else begin
            rd_vld_q <= acc_valid & ~|acc_we;
            if (acc_valid && acc_we == '0) rd_q <= mem[acc_addr];
        end
    end

    // R2 / R5: valid read data only follows a read command one edge earlier
    assert_rdvld_source_R2: assert property (@(posedge clk) disable iff (rst)
        rd_vld_q |-> $past(acc_valid && acc_we == '0));
endmodule

// File: rtl/bsram_top.sv
module bsram_top
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              sel,
    input  logic              cpu_stb,
    input  logic              ctl_stb,
    input  logic              adv,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic              oe,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    logic              acc_valid;
    logic [ADDR_W-1:0] acc_addr;
    logic [LANES-1:0]  acc_we;
    logic [DATA_W-1:0] acc_din;
    logic [DATA_W-1:0] rd_q;
    logic              rd_vld_q;

    bsram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .din       (din),
        .sel       (sel),
        .cpu_stb   (cpu_stb),
        .ctl_stb   (ctl_stb),
        .adv       (adv),
        .we_lo     (we_lo),
        .we_hi     (we_hi),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_we    (acc_we),
        .acc_din   (acc_din)
    );

    bsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_we    (acc_we),
        .acc_din   (acc_din),
        .rd_q      (rd_q),
        .rd_vld_q  (rd_vld_q)
    );

    // asynchronous output gate
    always_comb begin
        dout_en = oe & rd_vld_q;
        dout    = dout_en ? rd_q : '0;
    end

    // R3: output enable low forces the bus idle
    always_comb begin
        if (!oe) assert_oe_idle_R3: assert (!dout_en && dout == '0);
    end
endmodule

// File: tb/tb_bsram_top.sv
module tb_bsram_top;
    localparam int AW = 6;
    localparam int DW = 18;
    localparam int PER = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          sel = 1'b0, cpu_stb = 1'b0, ctl_stb = 1'b0, adv = 1'b0;
    logic          we_lo = 1'b0, we_hi = 1'b0, oe = 1'b1;
    logic [DW-1:0] dout;
    logic          dout_en;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_mem [1<<AW];

    always #(PER/2) clk = ~clk;

    bsram_top #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .addr(addr), .din(din), .sel(sel),
        .cpu_stb(cpu_stb), .ctl_stb(ctl_stb), .adv(adv),
        .we_lo(we_lo), .we_hi(we_hi), .oe(oe), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [DW-1:0] pat(int a);
        return DW'(a * 1237 + 18'h155A5);
    endfunction

    task automatic tick(input bit cs, input bit cc, input bit sl, input bit st,
                        input bit wl, input bit wh, input int a, input logic [DW-1:0] d);
        @(negedge clk);
        cpu_stb = cs; ctl_stb = cc; sel = sl; adv = st;
        we_lo = wl; we_hi = wh; addr = AW'(a); din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        tick(0, 0, 1, 0, 0, 0, 0, '0);
    endtask

    task automatic chk_word(input string req, input logic [DW-1:0] exp);
        checks++;
        if (dout_en !== 1'b1 || dout !== exp) begin
            errors++;
            $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=1 dout=%h", req, dout_en, dout, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        checks++;
        if (dout_en !== 1'b0 || dout !== '0) begin
            errors++;
            $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=0 dout=0", req, dout_en, dout);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk_idle("R1 after reset");
        idle();
        idle();
        chk_idle("R1 idle no access");
    endtask

    task automatic t_fill();
        for (int b = 0; b < (1<<AW); b += 4) begin
            int s = (b / 4) % 4;
            tick(0, 1, 1, 0, 1, 1, b | s, pat(b | s));
            exp_mem[b | s] = pat(b | s);
            for (int n = 1; n < 4; n++) begin
                tick(0, 0, 1, 1, 1, 1, 0, pat(b | (s ^ n)));
                exp_mem[b | (s ^ n)] = pat(b | (s ^ n));
            end
        end
        idle();
        chk_idle("R5 write cycle gives no read data");
    endtask

    task automatic t_read_burst();
        tick(1, 0, 1, 0, 0, 0, 'h15, '0);
        tick(0, 0, 1, 1, 0, 0, 0, '0); chk_word("R6 n=0", exp_mem['h15]);
        tick(0, 0, 1, 1, 0, 0, 0, '0); chk_word("R6 n=1", exp_mem['h14]);
        tick(0, 0, 1, 1, 0, 0, 0, '0); chk_word("R6 n=2", exp_mem['h17]);
        tick(0, 0, 1, 1, 0, 0, 0, '0); chk_word("R6 n=3", exp_mem['h16]);
        idle();                        chk_word("R6 wrap", exp_mem['h15]);
        idle();                        chk_word("R7 hold", exp_mem['h15]);
    endtask

    task automatic t_latency();
        tick(1, 0, 1, 0, 0, 0, 'h2B, '0);
        chk_word("R2 previous word until next edge", exp_mem['h15]);
        idle();
        chk_word("R2 one cycle latency", exp_mem['h2B]);
    endtask

    task automatic t_cpu_we();
        tick(1, 0, 1, 0, 1, 1, 'h30, '0);
        tick(0, 1, 1, 0, 0, 0, 'h30, '0);
        chk_word("R4 cpu strobe reads", exp_mem['h30]);
        idle();
        chk_word("R4 write enables ignored", exp_mem['h30]);
    endtask

    task automatic t_lanes();
        tick(0, 1, 1, 0, 1, 0, 'h08, 18'h3FFFF);
        exp_mem['h08] = {exp_mem['h08][17:9], 9'h1FF};
        tick(0, 1, 1, 0, 0, 1, 'h09, 18'h00000);
        exp_mem['h09] = {9'h000, exp_mem['h09][8:0]};
        chk_idle("R5 lower lane write no data");
        tick(0, 1, 1, 0, 0, 0, 'h08, '0);
        chk_idle("R5 upper lane write no data");
        tick(0, 1, 1, 0, 0, 0, 'h09, '0);
        chk_word("R5 lower lane bits 0..8 only", exp_mem['h08]);
        idle();
        chk_word("R5 upper lane bits 9..17 only", exp_mem['h09]);
        // R10 write in an advance cycle
        tick(0, 1, 1, 0, 1, 1, 'h0C, 18'h00111);
        tick(0, 0, 1, 1, 1, 1, 0, 18'h22222);
        exp_mem['h0C] = 18'h00111;
        exp_mem['h0D] = 18'h22222;
        tick(0, 1, 1, 0, 0, 0, 'h0D, '0);
        idle();
        chk_word("R10 advance write", exp_mem['h0D]);
    endtask

    task automatic t_oe();
        idle();
        chk_word("R3 baseline", exp_mem['h0D]);
        #2 oe = 1'b0;
        #1 chk_idle("R3 oe low drops output at once");
        oe = 1'b1;
        #1 chk_word("R3 oe high restores output", exp_mem['h0D]);
    endtask

    task automatic t_cpu_nosel();
        tick(0, 1, 1, 0, 0, 0, 'h10, '0);
        tick(1, 0, 0, 0, 0, 0, 'h3C, '0);
        idle();
        chk_word("R8 cpu strobe without select ignored", exp_mem['h10]);
        tick(1, 0, 0, 1, 0, 0, 'h3C, '0);
        idle();
        chk_word("R8 burst advances past ignored strobe", exp_mem['h11]);
    endtask

    task automatic t_desel();
        tick(0, 1, 1, 0, 0, 0, 'h20, '0);
        tick(0, 1, 0, 0, 0, 0, 'h20, '0);
        chk_word("R9 access before deselect", exp_mem['h20]);
        tick(0, 0, 1, 1, 1, 1, 'h21, '0);
        chk_idle("R9 deselected no read");
        tick(1, 0, 0, 0, 1, 1, 'h21, '0);
        chk_idle("R9 advance while deselected");
        tick(0, 1, 1, 0, 0, 0, 'h21, '0);
        chk_idle("R9 cpu strobe without select keeps deselect");
        idle();
        chk_word("R9 no write while deselected", exp_mem['h21]);
    endtask

    initial begin
        #(PER * 50000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        t_read_burst();
        t_latency();
        t_cpu_we();
        t_lanes();
        t_oe();
        t_cpu_nosel();
        t_desel();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule